// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block converts a 64-bit virtual address into a real frame address by reading translation tables from memory. It handles up to five levels: three region tables, a segment table and a page table. A 64-bit address-space descriptor picks the level where the walk begins and the origin of that first table. The walker issues one 8-byte table read at a time on a simple request/response memory port. Each returned entry is checked for validity, type and index window. Along the way the walker clears a write-permission flag whenever a protection bit applies.

A client presents the request while `idle` is high. Some time later `done` pulses for one cycle. With it come either a real frame address and a writable flag, or a nonzero exception code. Choosing the descriptor, assembling a full exception word, protection faults on stores and translation caching belong to neighbouring logic.

Top module: `ptw_walker`

## Requirements
- R1: The table index fields of the virtual address are bits 63:53 (first region), 52:42 (second region), 41:31 (third region), 30:20 (segment) and 19:12 (page). Every table read is issued at the table origin plus index times 8, so it is always 8-byte aligned. The descriptor origin is its bits 63:12, a region entry's next-table origin is its bits 63:12, and a segment entry's page-table origin is its bits 63:11.
- R2: The starting level comes from descriptor bits 3:2: 3 is the first region, 2 the second, 1 the third, 0 the segment. Before any read, the top two bits of that level's index are compared with descriptor bits 1:0. If they are greater, the walk ends with no read and with that level's translation code. Exception codes are: 0 none, 1 addressing, 2 descriptor-type, 3 first-region, 4 second-region, 5 third-region, 6 segment, 7 page, 8 specification.
- R3: When the walk starts below the first region level, any nonzero bit in a higher index field ends it with no read and code 2.
- R4: A region entry with bit 5 set gives that level's translation code. A region entry whose bits 3:2 are not 3, 2 or 1 (for first, second or third region respectively) gives code 8.
- R5: The top two bits of the next level's index must lie within the region entry's bits 7:6 and bits 1:0, both bounds inclusive. Otherwise the walk ends with the next level's translation code.
- R6: The writable flag starts at 1. Entry bit 9 clears it in a segment or page entry always, and in a region entry only when the enhanced-mode input is 1.
- R7: A segment entry with bit 5 set gives code 6. One with bits 3:2 nonzero gives code 8. One with bit 4 set while descriptor bit 8 (private space) is set gives code 8.
- R8: With enhanced mode on and segment entry bit 10 set, the walk ends after the segment read. The frame is the entry's bits 63:20 with zero below. With enhanced mode off, bit 10 is ignored and the page table is read.
- R9: A page entry with bit 10 set gives code 7, and one with bit 11 set gives code 8. Otherwise the frame is the entry's bits 63:12 with zero below.
- R10: A read answered with the error flag ends the walk with code 1.
- R11: With descriptor bit 5 (real space) set, no table is read. The result is the virtual address unchanged, writable 1 and code 0.
- R12: At most one read is outstanding, and each read request is a one-cycle pulse. `done` is a one-cycle pulse. A request is taken only while `idle`. With a nonzero code, the frame is 0 and writable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_vaddr | input | 64 | Virtual address to translate |
| req_asce | input | 64 | Address-space descriptor |
| req_edat | input | 1 | Enhanced mode: region protection and 1 MB frames |
| idle | output | 1 | Walker can accept a request |
| mem_rd_valid | output | 1 | One-cycle table read request |
| mem_rd_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Entry returned |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle result strobe |
| res_frame | output | 64 | Real frame address (or passthrough address) |
| res_writable | output | 1 | Write permitted for the frame |
| res_exc | output | 4 | Exception code, 0 when none |

## Verification
A five-level table tree is walked from each of the four entry levels while the page index is swept across sixteen values. This separates errors in per-level index slicing and origin arithmetic, which move the frame, from errors in level sequencing, which change the number of reads. Single-entry corruptions then set each invalid, type, window, common-segment, large-frame and page-reserved bit one at a time. A window test run at exactly the inclusive bound tells an off-by-one comparison apart from a correct one. Protection bits are placed at each level with enhanced mode on and off, which distinguishes region gating from unconditional clearing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        LV_PAGE = 3'd0,
        LV_SEG  = 3'd1,
        LV_RT3  = 3'd2,
        LV_RT2  = 3'd3,
        LV_RT1  = 3'd4
    } lvl_e;

    typedef enum logic [3:0] {
        EXC_NONE = 4'd0,
        EXC_ADDR = 4'd1,
        EXC_TYPE = 4'd2,
        EXC_RT1  = 4'd3,
        EXC_RT2  = 4'd4,
        EXC_RT3  = 4'd5,
        EXC_SEG  = 4'd6,
        EXC_PAGE = 4'd7,
        EXC_SPEC = 4'd8
    } exc_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } st_e;

    // translation code belonging to one table level
    function automatic exc_e trans_exc(input lvl_e lv);
        case (lv)
            LV_RT1:  return EXC_RT1;
            LV_RT2:  return EXC_RT2;
            LV_RT3:  return EXC_RT3;
            LV_SEG:  return EXC_SEG;
            default: return EXC_PAGE;
        endcase
    endfunction

endpackage

// File: rtl/ptw_vidx.sv
module ptw_vidx
    import ptw_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic [VA_W-1:0] vaddr,
    input  lvl_e            lvl,
    output logic [10:0]     idx,
    output logic [1:0]      win,
    output logic            above_nz
);
    localparam int NLV = 5;

    logic [10:0] fld  [NLV];
    logic [1:0]  wins [NLV];
    logic        hi   [NLV];

    for (genvar g = 0; g < NLV; g++) begin : g_lv
        localparam int LSB = (g == 0) ? 12 : (g == 1) ? 20 : (31 + 11 * (g - 2));
        localparam int W   = (g == 0) ? 8 : 11;
        assign fld[g]  = 11'(vaddr[LSB+W-1:LSB]);
        assign wins[g] = vaddr[LSB+W-1 -: 2];
        if (g < NLV - 1) begin : g_hi
            assign hi[g] = |vaddr[VA_W-1:LSB+W];
        end else begin : g_top
            assign hi[g] = 1'b0;
        end
    end

    assign idx      = fld[int'(lvl)];
    assign win      = wins[int'(lvl)];
    assign above_nz = hi[int'(lvl)];

    logic unused_lo;
    assign unused_lo = ^vaddr[11:0];
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic [VA_W-1:0] ent,
    input  lvl_e            lvl,
    input  logic [VA_W-1:0] vaddr,
    input  logic            edat,
    input  logic            priv,
    output exc_e            exc,
    output logic            clr_wr,
    output logic            leaf,
    output logic [VA_W-1:0] frame,
    output logic [VA_W-1:0] nxt_addr,
    output lvl_e            nxt_lvl
);
    localparam int PAD = VA_W - 14;

    logic [10:0] nidx;
    logic [1:0]  nwin;
    logic        unused_hi;
    logic [VA_W-1:0] noff;

    assign nxt_lvl = (lvl == LV_PAGE) ? LV_PAGE : lvl_e'(lvl - 3'd1);

    ptw_vidx #(.VA_W(VA_W)) u_nidx (
        .vaddr    (vaddr),
        .lvl      (nxt_lvl),
        .idx      (nidx),
        .win      (nwin),
        .above_nz (unused_hi)
    );

    assign noff = {{PAD{1'b0}}, nidx, 3'b000};

    always_comb begin
        exc      = EXC_NONE;
        clr_wr   = 1'b0;
        leaf     = 1'b0;
        frame    = '0;
        nxt_addr = '0;
        case (lvl)
            LV_PAGE: begin
                if (ent[10])      exc = EXC_PAGE;
                else if (ent[11]) exc = EXC_SPEC;
                else begin
                    clr_wr = ent[9];
                    leaf   = 1'b1;
                    frame  = {ent[VA_W-1:12], 12'b0};
                end
            end
            LV_SEG: begin
                if (ent[5])                exc = EXC_SEG;
                else if (ent[3:2] != 2'd0) exc = EXC_SPEC;
                else if (ent[4] && priv)   exc = EXC_SPEC;
                else begin
                    clr_wr = ent[9];
                    if (edat && ent[10]) begin
                        leaf  = 1'b1;
                        frame = {ent[VA_W-1:20], 20'b0};
                    end else begin
                        nxt_addr = {ent[VA_W-1:11], 11'b0} + noff;
                    end
                end
            end
            default: begin
                if (ent[5])                                  exc = trans_exc(lvl);
                else if ({1'b0, ent[3:2]} != 3'(lvl - 3'd1)) exc = EXC_SPEC;
                else if (nwin < ent[7:6] || nwin > ent[1:0]) exc = trans_exc(nxt_lvl);
                else begin
                    clr_wr   = edat & ent[9];
                    nxt_addr = {ent[VA_W-1:12], 12'b0} + noff;
                end
            end
        endcase
    end

    logic unused_b8;
    assign unused_b8 = ent[8];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] req_asce,
    input  logic            req_edat,
    output logic            idle,
    output logic            mem_rd_valid,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            done,
    output logic [VA_W-1:0] res_frame,
    output logic            res_writable,
    output logic [3:0]      res_exc
);
    localparam int PAD = VA_W - 14;

    typedef struct packed {
        st_e             st;
        lvl_e            lvl;
        logic [VA_W-1:0] vaddr;
        logic [VA_W-1:0] addr;
        logic [VA_W-1:0] frame;
        logic            wr;
        logic            edat;
        logic            priv;
        exc_e            exc;
    } walk_t;

    walk_t d, q;

    lvl_e        start_lvl;
    logic [10:0] st_idx;
    logic [1:0]  st_win;
    logic        st_hi;

    assign start_lvl = lvl_e'({1'b0, req_asce[3:2]} + 3'd1);

    ptw_vidx #(.VA_W(VA_W)) u_sidx (
        .vaddr    (req_vaddr),
        .lvl      (start_lvl),
        .idx      (st_idx),
        .win      (st_win),
        .above_nz (st_hi)
    );

    exc_e            ev_exc;
    logic            ev_clr;
    logic            ev_leaf;
    logic [VA_W-1:0] ev_frame;
    logic [VA_W-1:0] ev_nxt;
    lvl_e            ev_nlvl;

    ptw_entry_eval #(.VA_W(VA_W)) u_eval (
        .ent      (mem_rsp_data),
        .lvl      (q.lvl),
        .vaddr    (q.vaddr),
        .edat     (q.edat),
        .priv     (q.priv),
        .exc      (ev_exc),
        .clr_wr   (ev_clr),
        .leaf     (ev_leaf),
        .frame    (ev_frame),
        .nxt_addr (ev_nxt),
        .nxt_lvl  (ev_nlvl)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.vaddr = req_vaddr;
                    d.edat  = req_edat;
                    d.priv  = req_asce[8];
                    d.lvl   = start_lvl;
                    d.wr    = 1'b1;
                    d.frame = '0;
                    d.exc   = EXC_NONE;
                    if (req_asce[5]) begin
                        d.frame = req_vaddr;
                        d.st    = S_DONE;
                    end else if (st_hi) begin
                        d.exc = EXC_TYPE;
                        d.wr  = 1'b0;
                        d.st  = S_DONE;
                    end else if (st_win > req_asce[1:0]) begin
                        d.exc = trans_exc(start_lvl);
                        d.wr  = 1'b0;
                        d.st  = S_DONE;
                    end else begin
                        d.addr = {req_asce[VA_W-1:12], 12'b0} + {{PAD{1'b0}}, st_idx, 3'b000};
                        d.st   = S_ISSUE;
                    end
                end
            end
            S_ISSUE: d.st = S_WAIT;
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err || ev_exc != EXC_NONE) begin
                        d.exc   = mem_rsp_err ? EXC_ADDR : ev_exc;
                        d.wr    = 1'b0;
                        d.frame = '0;
                        d.st    = S_DONE;
                    end else begin
                        d.wr = q.wr & ~ev_clr;
                        if (ev_leaf) begin
                            d.frame = ev_frame;
                            d.st    = S_DONE;
                        end else begin
                            d.addr = ev_nxt;
                            d.lvl  = ev_nlvl;
                            d.st   = S_ISSUE;
                        end
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle         = (q.st == S_IDLE);
    assign mem_rd_valid = (q.st == S_ISSUE);
    assign mem_rd_addr  = q.addr;
    assign done         = (q.st == S_DONE);
    assign res_frame    = q.frame;
    assign res_writable = q.wr;
    assign res_exc      = q.exc;

    logic unused_asce;
    assign unused_asce = ^{req_asce[11:9], req_asce[7:6], req_asce[4]};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [VA_W-1:0] req_asce,
    input logic            idle,
    input logic            mem_rd_valid,
    input logic [VA_W-1:0] mem_rd_addr,
    input logic            done,
    input logic [VA_W-1:0] res_frame,
    input logic            res_writable,
    input logic [3:0]      res_exc
);
    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_rd_valid && !done); // R12

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_EXC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_exc != 4'd0) |-> (res_frame == '0 && !res_writable)); // R12

    AST_REAL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid && req_asce[5]) |=>
            (done && res_exc == 4'd0 && res_writable && res_frame == $past(req_vaddr))); // R11

    AST_TYPE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid && !req_asce[5] && req_asce[3:2] == 2'd0 && |req_vaddr[VA_W-1:31])
            |=> (done && res_exc == 4'd2)); // R3
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_asce = '0;
    logic        req_edat = 1'b0;
    logic        idle;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done;
    logic [63:0] res_frame;
    logic        res_writable;
    logic [3:0]  res_exc;

    always #2.5 clk = ~clk;

    ptw_walker #(.VA_W(64)) u0 (.*);

    int checks = 0;
    int errors = 0;
    int reads = 0;
    longint cycles = 0;
    logic [63:0] mem [logic [63:0]];

    localparam logic [3:0] C_NONE = 4'd0, C_ADDR = 4'd1, C_TYPE = 4'd2, C_RT1 = 4'd3,
                           C_RT2 = 4'd4, C_RT3 = 4'd5, C_SEG = 4'd6, C_PAGE = 4'd7,
                           C_SPEC = 4'd8;

    localparam logic [63:0] VA = (64'd1 << 53) | (64'd2 << 42) | (64'd3 << 31)
                               | (64'd4 << 20) | (64'd5 << 12) | 64'h123;
    localparam logic [63:0] M_R2 = 64'h001F_FFFF_FFFF_FFFF;
    localparam logic [63:0] M_R3 = 64'h0000_03FF_FFFF_FFFF;
    localparam logic [63:0] M_SG = 64'h0000_0000_7FFF_FFFF;
    localparam logic [63:0] A_R1 = 64'h1000F, A_R2 = 64'h2000B, A_R3 = 64'h30007, A_SG = 64'h40003;
    localparam logic [63:0] E_R1 = 64'h2000F, E_R2 = 64'h3000B, E_R3 = 64'h40007, E_SG = 64'h50000;

    // memory responder: sees a read at one negedge, answers one cycle later
    initial begin
        logic        pend;
        logic [63:0] paddr;
        pend = 1'b0;
        paddr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                if (mem.exists(paddr)) mem_rsp_data = mem[paddr];
                else begin
                    mem_rsp_data = 64'hDEAD_BEEF_DEAD_BEEF;
                    mem_rsp_err  = 1'b1;
                end
                pend = 1'b0;
            end
            if (mem_rd_valid) begin
                pend  = 1'b1;
                paddr = mem_rd_addr;
                reads++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] va, input logic [63:0] asce,
                       input logic edat, input logic [63:0] efr, input logic ewr,
                       input logic [3:0] eexc, input int ereads);
        int n;
        @(negedge clk);
        reads = 0;
        req_vaddr = va;
        req_asce  = asce;
        req_edat  = edat;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done"}, 64'(done), 64'd1);
        chk({tag, " exc"}, 64'(res_exc), 64'(eexc));
        chk({tag, " frame"}, res_frame, efr);
        chk({tag, " writable"}, 64'(res_writable), 64'(ewr));
        chk({tag, " reads"}, 64'(reads), 64'(ereads));
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] fr5;
        mem[64'h10008] = E_R1;
        mem[64'h20010] = E_R2;
        mem[64'h30018] = E_R3;
        mem[64'h40020] = E_SG;
        for (int px = 0; px < 16; px++)
            mem[64'h50000 + 64'(px) * 8] = (64'(px) << 20) | 64'h7000;
        fr5 = (64'd5 << 20) | 64'h7000;

        repeat (3) @(negedge clk);
        chk("R12 reset idle", 64'(idle), 64'd1);
        chk("R12 reset done", 64'(done), 64'd0);
        chk("R12 reset read", 64'(mem_rd_valid), 64'd0);
        rst_n = 1'b1;

        // R1 R2 sweep: each entry level, page index 0..15
        for (int s = 0; s < 4; s++) begin
            for (int px = 0; px < 16; px++) begin
                logic [63:0] va, asce, m;
                m    = (s == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (s == 1) ? M_R2 : (s == 2) ? M_R3 : M_SG;
                asce = (s == 0) ? A_R1 : (s == 1) ? A_R2 : (s == 2) ? A_R3 : A_SG;
                va   = ((VA & ~(64'hFF << 12)) | (64'(px) << 12)) & m;
                run("R1 sweep", va, asce, 1'b0, (64'(px) << 20) | 64'h7000, 1'b1, C_NONE, 5 - s);
            end
        end

        run("R11 real space", VA, A_R1 | 64'h20, 1'b0, VA, 1'b1, C_NONE, 0);
        run("R2 rt1 window", VA | (64'd1 << 62), 64'h1000C, 1'b0, 0, 1'b0, C_RT1, 0);
        run("R2 seg window", (VA & M_SG) | (64'd1 << 29), 64'h40000, 1'b0, 0, 1'b0, C_SEG, 0);
        run("R3 rt2 start", VA, A_R2, 1'b0, 0, 1'b0, C_TYPE, 0);
        run("R3 seg start", VA & M_R3, A_SG, 1'b0, 0, 1'b0, C_TYPE, 0);

        mem[64'h10008] = E_R1 | 64'h20;
        run("R4 rt1 invalid", VA, A_R1, 1'b0, 0, 1'b0, C_RT1, 1);
        mem[64'h10008] = E_R1 | 64'h40;
        run("R5 offset above index", VA, A_R1, 1'b0, 0, 1'b0, C_RT2, 1);
        mem[64'h10008] = E_R1;
        mem[64'h20010] = E_R2 | 64'h20;
        run("R4 rt2 invalid", VA, A_R1, 1'b0, 0, 1'b0, C_RT2, 2);
        mem[64'h20010] = 64'h30008;
        run("R5 length below index", VA | (64'd1 << 40), A_R1, 1'b0, 0, 1'b0, C_RT3, 2);
        mem[64'h20010] = 64'h30009;
        run("R5 R10 inclusive bound", VA | (64'd1 << 40), A_R1, 1'b0, 0, 1'b0, C_ADDR, 3);
        mem[64'h20010] = E_R2 | 64'h200;
        run("R6 region prot gated off", VA, A_R1, 1'b0, fr5, 1'b1, C_NONE, 5);
        run("R6 region prot enhanced", VA, A_R1, 1'b1, fr5, 1'b0, C_NONE, 5);
        mem[64'h20010] = E_R2;
        mem[64'h30018] = 64'h4000B;
        run("R4 rt3 wrong type", VA, A_R1, 1'b0, 0, 1'b0, C_SPEC, 3);
        mem[64'h30018] = E_R3;

        mem[64'h40020] = E_SG | 64'h200;
        run("R6 segment prot", VA, A_R1, 1'b0, fr5, 1'b0, C_NONE, 5);
        mem[64'h40020] = E_SG | 64'h20;
        run("R7 segment invalid", VA, A_R1, 1'b0, 0, 1'b0, C_SEG, 4);
        mem[64'h40020] = E_SG | 64'h4;
        run("R7 segment type", VA, A_R1, 1'b0, 0, 1'b0, C_SPEC, 4);
        mem[64'h40020] = E_SG | 64'h10;
        run("R7 common in private", VA, A_R1 | 64'h100, 1'b0, 0, 1'b0, C_SPEC, 4);
        run("R7 common in shared", VA, A_R1, 1'b0, fr5, 1'b1, C_NONE, 5);
        mem[64'h40020] = 64'h1230_0400;
        run("R8 large frame", VA, A_R1, 1'b1, 64'h1230_0000, 1'b1, C_NONE, 4);
        run("R8 R10 large ignored", VA, A_R1, 1'b0, 0, 1'b0, C_ADDR, 5);
        mem[64'h40020] = 64'h1230_0600;
        run("R8 large protected", VA, A_R1, 1'b1, 64'h1230_0000, 1'b0, C_NONE, 4);
        mem[64'h40020] = E_SG;

        mem[64'h50028] = fr5 | 64'h200;
        run("R6 page prot", VA, A_R1, 1'b0, fr5, 1'b0, C_NONE, 5);
        mem[64'h50028] = fr5 | 64'h400;
        run("R9 page invalid", VA, A_R1, 1'b0, 0, 1'b0, C_PAGE, 5);
        mem[64'h50028] = fr5 | 64'h800;
        run("R9 page reserved", VA, A_R1, 1'b0, 0, 1'b0, C_SPEC, 5);
        mem[64'h50028] = fr5 | 64'hFFF_0000_0000;
        run("R9 page high frame", VA, A_R1, 1'b0, fr5 | 64'hFFF_0000_0000, 1'b1, C_NONE, 5);
        mem[64'h50028] = fr5;

        run("R10 missing first table", VA, 64'h9000F, 1'b0, 0, 1'b0, C_ADDR, 1);
        run("R12 back to normal", VA, A_R1, 1'b0, fr5, 1'b1, C_NONE, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule